// File: doc/BRIEF.md
# Cache Line Coherency State Tracker

This block holds a 3-bit coherency status for each line of a small L1 data cache. Each line is 32 bytes wide. The block moves a line's status when a cache-management operation is applied to it. The caller presents a line index, an operation code, the write-through / caching-inhibited / memory-coherence attribute bits, a cache-target bit and a shared-response bit, then raises an apply strobe for one cycle. The new state is computed from four things: the operation, the attribute bits, the cache-target bit and the line's present status. It is written on the next clock edge.

At all times the block shows the stored status of the addressed line. It also shows four decoded one-hot flags (modified, exclusive, shared, invalid) and a combinational flag. That flag says whether the operation presented in the current cycle will change the line.

The block contains only the per-line state machine. Tag lookup, data storage, snooping and arbitration between processors belong to other blocks.

Top module: `coh_state_tracker`

## Requirements
- R1: Status codes are Modified = 3'b101, Exclusive = 3'b100 and Shared = 3'b110. Any code whose bit 2 is 0 is Invalid. After reset every line reads 3'b000. Exactly one of `flag_m_o`, `flag_e_o`, `flag_s_o` and `flag_i_o` is high, and `flag_i_o` equals the inverse of `state_o[2]`.
- R2: Allocate-zero (op 1) sets any line to Modified, provided that W (`wim_i[2]`) and I (`wim_i[1]`) are both 0.
- R3: Flush (op 2), invalidate (op 3) and store-block (op 4) set any line to Invalid (3'b000). The attribute bits do not matter for these operations.
- R4: Lock-clear (op 5) leaves the state unchanged for either value of `ct_i`. Op 0 and codes 10 to 15 also leave the state unchanged.
- R5: Read-touch (op 6) and read-touch-and-lock (op 7) need only I = 0.
  - With `ct_i` = 0, a line in M, E or S keeps its state.
  - With `ct_i` = 0, an Invalid line becomes Shared when `shared_i` = 1 and Exclusive when `shared_i` = 0.
  - With `ct_i` = 1, the line becomes Invalid.
- R6: Store-touch (op 8) needs W = 0 and I = 0.
  - With `ct_i` = 0, a line in M, E or S keeps its state, and an Invalid line becomes Exclusive whatever `shared_i` is.
  - With `ct_i` = 1, the line becomes Invalid.
- R7: Store-touch-and-lock (op 9) needs W = 0 and I = 0.
  - With `ct_i` = 0, a line in M or E keeps its state, and a line in S or I becomes Exclusive.
  - With `ct_i` = 1, the line becomes Invalid.
- R8: When the attribute condition of an operation is not met, the state is unchanged and `changed_o` stays low.
- R9: `changed_o` is high in the apply cycle exactly when the status will differ. The new status is visible from the clock edge that ends the apply cycle. During the apply cycle `state_o` still shows the old status.
- R10: When the index is at or above LINES, the operation is ignored: `changed_o` stays low, `state_o` reads 3'b000, and no line is altered.
- R11: An operation on one line leaves every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| apply_i | input | 1 | Apply the presented operation at the next edge |
| line_idx_i | input | IDX_W | Line index, used both for reading and for update |
| op_i | input | 4 | Operation code |
| wim_i | input | 3 | Attribute bits: [2] W, [1] I, [0] M |
| ct_i | input | 1 | Cache-target bit |
| shared_i | input | 1 | Shared response used when a read-touch fills an Invalid line |
| state_o | output | 3 | Stored status of the addressed line |
| flag_m_o | output | 1 | Addressed line is Modified |
| flag_e_o | output | 1 | Addressed line is Exclusive |
| flag_s_o | output | 1 | Addressed line is Shared |
| flag_i_o | output | 1 | Addressed line is Invalid |
| changed_o | output | 1 | The presented operation will change the addressed line |

## Verification
The bench first drives each line into a known state using only legal operations. It then exercises every operation against each starting state and each attribute condition, and targets the following corner cases:
- Store-touch-and-lock upgrading Shared to Exclusive. A design that reused the plain store-touch rule would leave the line Shared.
- Read-touch with W = 1. This is legal for a read-touch, so a design that checked W here would wrongly block the fill.
- Store-touch ignoring `shared_i`. A design that copied the read-touch path would produce Shared.
- An index past the line count. A design that truncated the index would alias onto line 36 and corrupt it.
- A read of the addressed line during the apply cycle. A design with a write-through read path would show the new state one cycle early.

// File: rtl/coh_pkg.sv
package coh_pkg;

  localparam int ST_W = 3;
  typedef logic [ST_W-1:0] cstate_t;

  localparam cstate_t ST_INV = 3'b000;
  localparam cstate_t ST_SHR = 3'b110;
  localparam cstate_t ST_EXC = 3'b100;
  localparam cstate_t ST_MOD = 3'b101;

  typedef enum logic [3:0] {
    OP_NONE          = 4'd0,
    OP_ALLOC_ZERO    = 4'd1,
    OP_FLUSH         = 4'd2,
    OP_INVAL         = 4'd3,
    OP_STORE_BLK     = 4'd4,
    OP_LOCK_CLR      = 4'd5,
    OP_RD_TOUCH      = 4'd6,
    OP_RD_TOUCH_LOCK = 4'd7,
    OP_ST_TOUCH      = 4'd8,
    OP_ST_TOUCH_LOCK = 4'd9
  } cop_e;

  // Attribute bit positions within the 3-bit attribute field.
  localparam int WIM_W_BIT = 2;
  localparam int WIM_I_BIT = 1;

  function automatic logic st_valid(cstate_t s);
    return s[2];
  endfunction

  function automatic logic st_is_mod(cstate_t s);
    return s[2] & ~s[1] & s[0];
  endfunction

  function automatic logic st_is_exc(cstate_t s);
    return s[2] & ~s[1] & ~s[0];
  endfunction

  function automatic logic st_is_shr(cstate_t s);
    return s[2] & s[1];
  endfunction

  // Write-through and caching-inhibited both clear.
  function automatic logic wim_allows_store(logic [2:0] wim);
    return ~wim[WIM_W_BIT] & ~wim[WIM_I_BIT];
  endfunction

  // Caching-inhibited clear.
  function automatic logic wim_allows_read(logic [2:0] wim);
    return ~wim[WIM_I_BIT];
  endfunction

  function automatic cstate_t next_state(cstate_t cur, logic [3:0] op,
                                         logic [2:0] wim, logic ct,
                                         logic shr);
    cstate_t nxt;
    nxt = cur;
    case (op)
      OP_ALLOC_ZERO:
        if (wim_allows_store(wim)) nxt = ST_MOD;
      OP_FLUSH, OP_INVAL, OP_STORE_BLK:
        nxt = ST_INV;
      OP_RD_TOUCH, OP_RD_TOUCH_LOCK:
        if (wim_allows_read(wim)) begin
          if (ct) nxt = ST_INV;
          else if (!st_valid(cur)) nxt = shr ? ST_SHR : ST_EXC;
        end
      OP_ST_TOUCH:
        if (wim_allows_store(wim)) begin
          if (ct) nxt = ST_INV;
          else if (!st_valid(cur)) nxt = ST_EXC;
        end
      OP_ST_TOUCH_LOCK:
        if (wim_allows_store(wim)) begin
          if (ct) nxt = ST_INV;
          else if (!st_valid(cur) || st_is_shr(cur)) nxt = ST_EXC;
        end
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/coh_next_state.sv
module coh_next_state
  import coh_pkg::*;
(
  input  cstate_t    cur_i,
  input  logic [3:0] op_i,
  input  logic [2:0] wim_i,
  input  logic       ct_i,
  input  logic       shared_i,
  output cstate_t    nxt_o,
  output logic       differs_o
);
  always_comb begin
    nxt_o     = next_state(cur_i, op_i, wim_i, ct_i, shared_i);
    differs_o = (nxt_o != cur_i);
  end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  cstate_t          wr_data_i,
  output cstate_t          rd_data_o
);
  cstate_t lines_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) lines_q[g] <= ST_INV;
      else if (wr_en_i && idx_i == IDX_W'(g)) lines_q[g] <= wr_data_i;
    end
  end

  // An index with no matching line reads as Invalid.
  always_comb begin
    rd_data_o = ST_INV;
    for (int k = 0; k < LINES; k++)
      if (idx_i == IDX_W'(k)) rd_data_o = lines_q[k];
  end
endmodule

// File: rtl/coh_flag_decode.sv
module coh_flag_decode
  import coh_pkg::*;
(
  input  cstate_t st_i,
  output logic    m_o,
  output logic    e_o,
  output logic    s_o,
  output logic    i_o
);
  always_comb begin
    m_o = st_is_mod(st_i);
    e_o = st_is_exc(st_i);
    s_o = st_is_shr(st_i);
    i_o = ~st_valid(st_i);
  end
endmodule

// File: rtl/coh_state_tracker.sv
module coh_state_tracker
  import coh_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply_i,
  input  logic [IDX_W-1:0] line_idx_i,
  input  logic [3:0]       op_i,
  input  logic [2:0]       wim_i,
  input  logic             ct_i,
  input  logic             shared_i,
  output logic [2:0]       state_o,
  output logic             flag_m_o,
  output logic             flag_e_o,
  output logic             flag_s_o,
  output logic             flag_i_o,
  output logic             changed_o
);
  localparam logic [IDX_W:0] LINE_LIMIT = (IDX_W+1)'(LINES);

  cstate_t cur_state_w;
  cstate_t nxt_state_w;
  logic    differs_w;
  logic    in_range_w;
  logic    wr_en_w;

  assign in_range_w = ({1'b0, line_idx_i} < LINE_LIMIT);
  assign wr_en_w    = apply_i & in_range_w & differs_w;
  assign changed_o  = wr_en_w;
  assign state_o    = cur_state_w;

  coh_line_store #(.LINES(LINES), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_w),
    .idx_i     (line_idx_i),
    .wr_data_i (nxt_state_w),
    .rd_data_o (cur_state_w)
  );

  coh_next_state u_next (
    .cur_i     (cur_state_w),
    .op_i      (op_i),
    .wim_i     (wim_i),
    .ct_i      (ct_i),
    .shared_i  (shared_i),
    .nxt_o     (nxt_state_w),
    .differs_o (differs_w)
  );

  coh_flag_decode u_flags (
    .st_i (cur_state_w),
    .m_o  (flag_m_o),
    .e_o  (flag_e_o),
    .s_o  (flag_s_o),
    .i_o  (flag_i_o)
  );
endmodule

// File: rtl/coh_state_tracker_chk.sv
module coh_state_tracker_chk
  import coh_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             apply_i,
  input logic [IDX_W-1:0] line_idx_i,
  input logic [3:0]       op_i,
  input logic [2:0]       wim_i,
  input logic [2:0]       state_o,
  input logic             flag_m_o,
  input logic             flag_e_o,
  input logic             flag_s_o,
  input logic             flag_i_o,
  input logic             changed_o,
  input logic             in_range_w,
  input logic [2:0]       nxt_state_w
);
  // R1
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_m_o, flag_e_o, flag_s_o, flag_i_o}) == 1);

  // R1
  inv_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_i_o == ~state_o[2]);

  // R2
  alloc_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && op_i == OP_ALLOC_ZERO && !wim_i[2] && !wim_i[1])
      |-> nxt_state_w == ST_MOD);

  // R3
  kill_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && (op_i == OP_FLUSH || op_i == OP_INVAL || op_i == OP_STORE_BLK))
      |-> !nxt_state_w[2]);

  // R4
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && op_i == OP_LOCK_CLR) |-> !changed_o);

  // R8
  store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && (wim_i[2] || wim_i[1]) &&
     (op_i == OP_ALLOC_ZERO || op_i == OP_ST_TOUCH || op_i == OP_ST_TOUCH_LOCK))
      |-> !changed_o);

  // R9
  update_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(changed_o) && $stable(line_idx_i))
      |-> state_o == $past(nxt_state_w));

  // R10
  range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range_w |-> (!changed_o && state_o == ST_INV));
endmodule

bind coh_state_tracker coh_state_tracker_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .apply_i     (apply_i),
  .line_idx_i  (line_idx_i),
  .op_i        (op_i),
  .wim_i       (wim_i),
  .state_o     (state_o),
  .flag_m_o    (flag_m_o),
  .flag_e_o    (flag_e_o),
  .flag_s_o    (flag_s_o),
  .flag_i_o    (flag_i_o),
  .changed_o   (changed_o),
  .in_range_w  (in_range_w),
  .nxt_state_w (nxt_state_w)
);

// File: tb/coh_state_tracker_test.sv
module coh_state_tracker_test;
  localparam int LINES = 64;
  localparam int IDX_W = 7;

  localparam logic [2:0] SI = 3'b000, SS = 3'b110, SE = 3'b100, SM = 3'b101;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             apply_i = 1'b0;
  logic [IDX_W-1:0] line_idx_i = '0;
  logic [3:0]       op_i = '0;
  logic [2:0]       wim_i = '0;
  logic             ct_i = 1'b0;
  logic             shared_i = 1'b0;
  logic [2:0]       state_o;
  logic             flag_m_o, flag_e_o, flag_s_o, flag_i_o, changed_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  coh_state_tracker #(.LINES(LINES), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .apply_i(apply_i), .line_idx_i(line_idx_i),
    .op_i(op_i), .wim_i(wim_i), .ct_i(ct_i), .shared_i(shared_i),
    .state_o(state_o), .flag_m_o(flag_m_o), .flag_e_o(flag_e_o),
    .flag_s_o(flag_s_o), .flag_i_o(flag_i_o), .changed_o(changed_o)
  );

  // Vector fields: init[15:13] op[12:9] wim[8:6] ct[5] sh[4] exp[3:1] chg[0]
  localparam int NV = 24;
  localparam logic [15:0] VECS [NV] = '{
    {SI, 4'd1, 3'b000, 1'b0, 1'b0, SM, 1'b1},  // R2
    {SS, 4'd1, 3'b001, 1'b0, 1'b0, SM, 1'b1},  // R2
    {SE, 4'd1, 3'b100, 1'b0, 1'b0, SE, 1'b0},  // R8
    {SS, 4'd1, 3'b010, 1'b0, 1'b0, SS, 1'b0},  // R8
    {SM, 4'd2, 3'b111, 1'b0, 1'b0, SI, 1'b1},  // R3
    {SE, 4'd3, 3'b010, 1'b0, 1'b0, SI, 1'b1},  // R3
    {SS, 4'd4, 3'b100, 1'b0, 1'b0, SI, 1'b1},  // R3
    {SI, 4'd2, 3'b000, 1'b0, 1'b0, SI, 1'b0},  // R3
    {SM, 4'd5, 3'b000, 1'b1, 1'b0, SM, 1'b0},  // R4
    {SE, 4'd5, 3'b000, 1'b0, 1'b0, SE, 1'b0},  // R4
    {SI, 4'd6, 3'b000, 1'b0, 1'b1, SS, 1'b1},  // R5
    {SI, 4'd6, 3'b100, 1'b0, 1'b0, SE, 1'b1},  // R5
    {SM, 4'd6, 3'b000, 1'b0, 1'b1, SM, 1'b0},  // R5
    {SS, 4'd7, 3'b001, 1'b1, 1'b0, SI, 1'b1},  // R5
    {SI, 4'd7, 3'b010, 1'b0, 1'b0, SI, 1'b0},  // R8
    {SS, 4'd8, 3'b000, 1'b0, 1'b0, SS, 1'b0},  // R6
    {SI, 4'd8, 3'b000, 1'b0, 1'b1, SE, 1'b1},  // R6
    {SE, 4'd8, 3'b000, 1'b1, 1'b0, SI, 1'b1},  // R6
    {SM, 4'd8, 3'b100, 1'b1, 1'b0, SM, 1'b0},  // R8
    {SS, 4'd9, 3'b000, 1'b0, 1'b0, SE, 1'b1},  // R7
    {SM, 4'd9, 3'b000, 1'b0, 1'b0, SM, 1'b0},  // R7
    {SI, 4'd9, 3'b000, 1'b0, 1'b1, SE, 1'b1},  // R7
    {SE, 4'd9, 3'b000, 1'b1, 1'b0, SI, 1'b1},  // R7
    {SE, 4'd0, 3'b000, 1'b0, 1'b0, SE, 1'b0}   // R4
  };

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One apply cycle; inputs change at the falling edge.
  task automatic drive(logic [IDX_W-1:0] idx, logic [3:0] op, logic [2:0] wim,
                       logic ct, logic sh);
    @(negedge clk);
    line_idx_i = idx; op_i = op; wim_i = wim; ct_i = ct; shared_i = sh;
    apply_i = 1'b1;
    @(negedge clk);
    apply_i = 1'b0;
  endtask

  task automatic set_state(logic [IDX_W-1:0] idx, logic [2:0] st);
    drive(idx, 4'd2, 3'b000, 1'b0, 1'b0);
    case (st)
      SM: drive(idx, 4'd1, 3'b000, 1'b0, 1'b0);
      SE: drive(idx, 4'd6, 3'b000, 1'b0, 1'b0);
      SS: drive(idx, 4'd6, 3'b000, 1'b0, 1'b1);
      default: ;
    endcase
  endtask

  task automatic read_line(logic [IDX_W-1:0] idx, output logic [2:0] st);
    @(negedge clk);
    line_idx_i = idx; apply_i = 1'b0;
    #1 st = state_o;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [2:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of several lines, flags
    for (int k = 0; k < LINES; k += 21) begin
      read_line(IDX_W'(k), st);
      check(st == SI && flag_i_o && !flag_m_o && !flag_e_o && !flag_s_o,
            "R1 reset line", {5'b0, st}, {5'b0, SI});
    end

    // Table walk on line 5
    for (int v = 0; v < NV; v++) begin
      logic [15:0] vec;
      vec = VECS[v];
      set_state(7'd5, vec[15:13]);
      @(negedge clk);
      line_idx_i = 7'd5; op_i = vec[12:9]; wim_i = vec[8:6];
      ct_i = vec[5]; shared_i = vec[4]; apply_i = 1'b1;
      #1;
      check(changed_o == vec[0], $sformatf("R2-R8 vec%0d changed", v),
            {7'b0, changed_o}, {7'b0, vec[0]});
      check(state_o == vec[15:13], $sformatf("R9 vec%0d old state", v),
            {5'b0, state_o}, {5'b0, vec[15:13]});
      @(negedge clk);
      apply_i = 1'b0;
      #1;
      check(state_o == vec[3:1], $sformatf("R2-R8 vec%0d new state", v),
            {5'b0, state_o}, {5'b0, vec[3:1]});
      check(flag_m_o == (vec[3:1] == SM) && flag_e_o == (vec[3:1] == SE) &&
            flag_s_o == (vec[3:1] == SS) && flag_i_o == (vec[3:1] == SI),
            $sformatf("R1 vec%0d flags", v),
            {4'b0, flag_m_o, flag_e_o, flag_s_o, flag_i_o}, {5'b0, vec[3:1]});
    end

    // R11: line 8 untouched while line 7 is changed
    set_state(7'd8, SS);
    set_state(7'd7, SM);
    drive(7'd7, 4'd3, 3'b000, 1'b0, 1'b0);
    read_line(7'd8, st);
    check(st == SS, "R11 neighbour line kept", {5'b0, st}, {5'b0, SS});
    read_line(7'd7, st);
    check(st == SI, "R11 target line invalidated", {5'b0, st}, {5'b0, SI});

    // R10: out-of-range index 100 (aliases line 36 if truncated)
    set_state(7'd36, SI);
    @(negedge clk);
    line_idx_i = 7'd100; op_i = 4'd1; wim_i = 3'b000; apply_i = 1'b1;
    #1;
    check(!changed_o, "R10 out-of-range changed", {7'b0, changed_o}, 8'h0);
    check(state_o == SI, "R10 out-of-range read", {5'b0, state_o}, {5'b0, SI});
    @(negedge clk);
    apply_i = 1'b0;
    read_line(7'd36, st);
    check(st == SI, "R10 line 36 not aliased", {5'b0, st}, {5'b0, SI});
    read_line(7'd63, st);
    check(st == SI, "R10 last line untouched", {5'b0, st}, {5'b0, SI});

    // R9: two back-to-back applies on the same line
    set_state(7'd9, SI);
    @(negedge clk);
    line_idx_i = 7'd9; op_i = 4'd6; wim_i = 3'b000; ct_i = 1'b0;
    shared_i = 1'b1; apply_i = 1'b1;
    @(negedge clk);
    op_i = 4'd9; shared_i = 1'b0;
    #1;
    check(state_o == SS && changed_o, "R9 back-to-back first result",
          {4'b0, changed_o, state_o}, {5'b0, SS} | 8'h8);
    @(negedge clk);
    apply_i = 1'b0;
    #1;
    check(state_o == SE, "R9 back-to-back second result", {5'b0, state_o}, {5'b0, SE});

    // R1: reset clears a modified line
    set_state(7'd12, SM);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_line(7'd12, st);
    check(st == SI, "R1 reset clears modified", {5'b0, st}, {5'b0, SI});

    done = 1'b1;
    report();
  end
endmodule